// File: doc/BRIEF.md
# SDRAM Bring-Up and Refresh Sequencer

This block sits at the front of a controller for a four-bank, 32-bit mobile SDRAM. After reset it keeps the clock enable high and sends no-operation commands for a programmable settling window. It then runs the start-up sequence: close all rows, run a set number of auto-refresh cycles, write the normal mode register, and write the extended mode register. Each command waits for its own minimum spacing in clock cycles. The mode words are built from configuration inputs. Burst length, burst type, read latency and single-location write select go to the normal register. The refreshed self-refresh area and the output drive strength go to the extended register.

Once the extended-register wait has passed, `ready` rises and stays high. An interval timer then marks an auto-refresh as due every `REF_INT_CYC` cycles. A user read/write engine asks for the command bus with `usr_req` and owns it while `usr_gnt` is high. A due refresh blocks new grants. It is issued only once the user has let the bus go, and the user must leave all banks precharged when it does. All command, bank and address outputs are registered.

Top module: `sdram_bringup_seq`

## Requirements
- R1: While `rst` is high, the outputs are `cke`=1, a NOP command, `ba`=0, `addr`=0, `ready`=0 and `usr_gnt`=0. Commands are encoded on {`cs_n`,`ras_n`,`cas_n`,`we_n`} as NOP 0111, precharge 0010, auto-refresh 0001 and mode-register write 0000.
- R2: `cke` is held at 1. Counting the first cycle after reset release as cycle 0, every cycle before cycle `T_PWRUP_CYC` carries a NOP.
- R3: In cycle `T_PWRUP_CYC` a precharge with `addr[10]`=1 (all banks) and the other address bits at 0 is issued. `N_INIT_REF` auto-refreshes follow: the first comes `T_RP_CYC` cycles after the precharge, and each later one comes `T_RC_CYC` cycles after the one before it.
- R4: The normal mode write is issued `T_RC_CYC` cycles after the last start-up refresh, with `ba`=00. Its address bits are: A2..A0 burst length, A3 burst type, A6..A4 read latency, A9 single-location write, and A12..A10, A8 and A7 all 0.
- R5: The extended mode write is issued `T_MRD_CYC` cycles after the normal one, with `ba`=10. Its address bits are: A2..A0 refreshed area, A6..A5 drive strength, and every other bit 0.
- R6: `ready` rises exactly `T_MRD_CYC` cycles after the extended mode write and never falls until reset. Any non-NOP command is followed by a NOP in the next cycle.
- R7: With no user traffic, an auto-refresh is issued `REF_INT_CYC`+1 cycles after `ready` rises, and again every `REF_INT_CYC` cycles after that. All other cycles carry NOP.
- R8: `usr_gnt` is never high while `ready` is low. When `ready` is high, no refresh is due and the last refresh's `T_RC_CYC` window has passed, `usr_gnt` rises in the cycle after `usr_req` is first seen high. It stays high while `usr_req` stays high.
- R9: A due refresh neither takes nor shortens a grant that is already held. It is issued in the second cycle after `usr_req` drops. A request raised while a refresh is due is granted only `T_RC_CYC` cycles after that refresh is issued.
- R10: While `usr_gnt` is high, the sequencer drives NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_len | input | 3 | Burst length code for A2..A0 of the normal mode word |
| cfg_burst_ilv | input | 1 | Burst type (1 interleaved) for A3 |
| cfg_rd_lat | input | 3 | Read latency code for A6..A4 |
| cfg_single_wr | input | 1 | Single-location write select for A9 |
| cfg_sr_area | input | 3 | Refreshed self-refresh area code for A2..A0 of the extended word |
| cfg_drive | input | 2 | Drive strength code for A6..A5 of the extended word |
| usr_req | input | 1 | User engine requests the command bus |
| usr_gnt | output | 1 | Command bus granted to the user engine |
| ready | output | 1 | Start-up sequence finished |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 13 | Multiplexed address |

## Verification
Some properties are checked on every cycle:
- A grant never appears without `ready`.
- The command is NOP whenever the grant is held.
- `ready` never drops.
- Every command is followed by a NOP.
- A refresh after start-up never comes in the cycle after a grant.
- No grant starts while a refresh is due.

Other behaviour can only be shown by the bench scenarios, because it concerns exact cycle positions and field contents:
- The placement and address words of the start-up commands.
- The refresh period.
- The two-cycle release delay when a refresh has been deferred.
- The `T_RC_CYC` hold-off on a request that collides with a due refresh.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MODE = 4'b0000,
    CMD_AREF = 4'b0001,
    CMD_PALL = 4'b0010,
    CMD_NOP  = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_INITREF,
    ST_MODE,
    ST_EXTMODE,
    ST_LASTWAIT,
    ST_RUN
  } seq_state_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_gap_timer.sv
module seq_gap_timer #(
  parameter int unsigned W        = 8,
  parameter int unsigned INIT_VAL = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)
      remain <= W'(INIT_VAL);
    else if (load)
      remain <= load_val;
    else if (remain != '0)
      remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);

endmodule

// File: rtl/seq_refresh_tick.sv
module seq_refresh_tick #(
  parameter int unsigned INTERVAL = 1040
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ack,
  output logic pend
);

  localparam int unsigned CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (en)
        cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap)
        pend <= 1'b1;
      else if (ack)
        pend <= 1'b0;
    end
  end

endmodule

// File: rtl/seq_mode_words.sv
module seq_mode_words (
  input  logic [2:0]  burst_len,
  input  logic        burst_ilv,
  input  logic [2:0]  rd_lat,
  input  logic        single_wr,
  input  logic [2:0]  sr_area,
  input  logic [1:0]  drive,
  output logic [12:0] norm_word,
  output logic [12:0] ext_word
);

  always_comb begin
    norm_word        = '0;
    norm_word[2:0]   = burst_len;
    norm_word[3]     = burst_ilv;
    norm_word[6:4]   = rd_lat;
    norm_word[9]     = single_wr;
    ext_word         = '0;
    ext_word[2:0]    = sr_area;
    ext_word[6:5]    = drive;
  end

endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned T_PWRUP_CYC = 10000,
  parameter int unsigned T_RP_CYC    = 3,
  parameter int unsigned T_RC_CYC    = 9,
  parameter int unsigned T_MRD_CYC   = 2,
  parameter int unsigned N_INIT_REF  = 2,
  parameter int unsigned REF_INT_CYC = 1040
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  cfg_burst_len,
  input  logic        cfg_burst_ilv,
  input  logic [2:0]  cfg_rd_lat,
  input  logic        cfg_single_wr,
  input  logic [2:0]  cfg_sr_area,
  input  logic [1:0]  cfg_drive,
  input  logic        usr_req,
  output logic        usr_gnt,
  output logic        ready,
  output logic        cke,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [12:0] addr
);

  localparam int unsigned T_MAX = max_of(max_of(T_PWRUP_CYC, T_RP_CYC), max_of(T_RC_CYC, T_MRD_CYC));
  localparam int unsigned TW    = $clog2(T_MAX + 1);
  localparam int unsigned NW    = (N_INIT_REF > 1) ? $clog2(N_INIT_REF) : 1;

  seq_state_e  state, nxt_state;
  sd_cmd_e     cmd_q, nxt_cmd;
  logic [1:0]  ba_q, nxt_ba;
  logic [12:0] addr_q, nxt_addr;
  logic        ready_q, gnt_q, nxt_gnt;
  logic [NW-1:0] nref_q, nxt_nref;
  logic        tm_load, tm_exp;
  logic [TW-1:0] tm_val;
  logic        ref_pend, ref_issue;
  logic [12:0] norm_word, ext_word;

  seq_gap_timer #(.W(TW), .INIT_VAL(T_PWRUP_CYC - 1)) u_gap (
    .clk(clk), .rst(rst), .load(tm_load), .load_val(tm_val), .expired(tm_exp)
  );

  seq_refresh_tick #(.INTERVAL(REF_INT_CYC)) u_tick (
    .clk(clk), .rst(rst), .en(ready_q), .ack(ref_issue), .pend(ref_pend)
  );

  seq_mode_words u_words (
    .burst_len(cfg_burst_len), .burst_ilv(cfg_burst_ilv), .rd_lat(cfg_rd_lat),
    .single_wr(cfg_single_wr), .sr_area(cfg_sr_area), .drive(cfg_drive),
    .norm_word(norm_word), .ext_word(ext_word)
  );

  always_comb begin
    nxt_state = state;
    nxt_cmd   = CMD_NOP;
    nxt_ba    = 2'b00;
    nxt_addr  = '0;
    nxt_nref  = nref_q;
    tm_load   = 1'b0;
    tm_val    = '0;
    ref_issue = 1'b0;
    case (state)
      ST_SETTLE: if (tm_exp) begin
        nxt_cmd      = CMD_PALL;
        nxt_addr[10] = 1'b1;
        tm_load      = 1'b1;
        tm_val       = TW'(T_RP_CYC - 1);
        nxt_state    = ST_INITREF;
      end
      ST_INITREF: if (tm_exp) begin
        nxt_cmd = CMD_AREF;
        tm_load = 1'b1;
        tm_val  = TW'(T_RC_CYC - 1);
        if (nref_q == NW'(N_INIT_REF - 1))
          nxt_state = ST_MODE;
        else
          nxt_nref = nref_q + 1'b1;
      end
      ST_MODE: if (tm_exp) begin
        nxt_cmd   = CMD_MODE;
        nxt_addr  = norm_word;
        tm_load   = 1'b1;
        tm_val    = TW'(T_MRD_CYC - 1);
        nxt_state = ST_EXTMODE;
      end
      ST_EXTMODE: if (tm_exp) begin
        nxt_cmd   = CMD_MODE;
        nxt_ba    = 2'b10;
        nxt_addr  = ext_word;
        tm_load   = 1'b1;
        tm_val    = TW'(T_MRD_CYC - 1);
        nxt_state = ST_LASTWAIT;
      end
      ST_LASTWAIT: if (tm_exp) nxt_state = ST_RUN;
      ST_RUN: if (ref_pend && !gnt_q && tm_exp) begin
        nxt_cmd   = CMD_AREF;
        tm_load   = 1'b1;
        tm_val    = TW'(T_RC_CYC - 1);
        ref_issue = 1'b1;
      end
      default: nxt_state = ST_SETTLE;
    endcase
    nxt_gnt = (state == ST_RUN) && usr_req &&
              (gnt_q || (!ref_pend && tm_exp && !ref_issue));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_SETTLE;
      cmd_q   <= CMD_NOP;
      ba_q    <= 2'b00;
      addr_q  <= '0;
      nref_q  <= '0;
      ready_q <= 1'b0;
      gnt_q   <= 1'b0;
    end else begin
      state   <= nxt_state;
      cmd_q   <= nxt_cmd;
      ba_q    <= nxt_ba;
      addr_q  <= nxt_addr;
      nref_q  <= nxt_nref;
      ready_q <= (nxt_state == ST_RUN);
      gnt_q   <= nxt_gnt;
    end
  end

  assign cke     = 1'b1;
  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ba      = ba_q;
  assign addr    = addr_q;
  assign ready   = ready_q;
  assign usr_gnt = gnt_q;

  AST_GNT_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    gnt_q |-> ready_q); // R8
  AST_NOP_WHILE_GNT: assert property (@(posedge clk) disable iff (rst)
    gnt_q |-> (cmd_q == CMD_NOP)); // R10
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> ready_q); // R6
  AST_CMD_THEN_NOP: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP)); // R6
  AST_REF_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (ready_q && $past(ready_q) && cmd_q == CMD_AREF) |-> $past(!gnt_q)); // R9
  AST_NO_GNT_ON_PEND: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_q) |-> $past(!ref_pend)); // R9

endmodule

// File: tb/sim_sdram_bringup_seq.sv
module sim_sdram_bringup_seq;

  localparam int unsigned P_PWR = 20;
  localparam int unsigned P_RP  = 3;
  localparam int unsigned P_RC  = 9;
  localparam int unsigned P_MRD = 2;
  localparam int unsigned P_INT = 100;

  localparam int NV = 6;
  localparam int          VEC_N    [NV] = '{20, 23, 32, 41, 43, 146};
  localparam logic [3:0]  VEC_CMD  [NV] = '{4'b0010, 4'b0001, 4'b0001, 4'b0000, 4'b0000, 4'b0001};
  localparam logic [1:0]  VEC_BA   [NV] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00};
  localparam logic [12:0] VEC_ADDR [NV] = '{13'h400, 13'h000, 13'h000, 13'h23B, 13'h021, 13'h000};
  localparam string       VEC_REQ  [NV] = '{"R3", "R3", "R3", "R4", "R5", "R7"};
  localparam int READY_N = 45;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic usr_req = 1'b0;
  logic usr_gnt, ready, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [12:0] addr;

  int n_tests = 0;
  int n_fail  = 0;
  int n = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  sdram_bringup_seq #(
    .T_PWRUP_CYC(P_PWR), .T_RP_CYC(P_RP), .T_RC_CYC(P_RC),
    .T_MRD_CYC(P_MRD), .N_INIT_REF(2), .REF_INT_CYC(P_INT)
  ) u0 (
    .clk(clk), .rst(rst),
    .cfg_burst_len(3'b011), .cfg_burst_ilv(1'b1), .cfg_rd_lat(3'b011),
    .cfg_single_wr(1'b1), .cfg_sr_area(3'b001), .cfg_drive(2'b01),
    .usr_req(usr_req), .usr_gnt(usr_gnt), .ready(ready), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
  );

  function automatic logic [3:0] cmd_now();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at n=%0d: actual=%0h expected=%0h", req, what, n, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    n++;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 3000) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual=%0d expected<=3000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_now() == 4'b0111, "R1", "cmd", cmd_now(), 4'b0111);
    chk(cke == 1'b1, "R1", "cke", cke, 1);
    chk(ready == 1'b0 && usr_gnt == 1'b0, "R1", "ready/gnt", {ready, usr_gnt}, 0);
    chk(addr == 13'd0 && ba == 2'd0, "R1", "addr/ba", {ba, addr}, 0);
    rst = 1'b0;
    n = 0;

    // vector walk: start-up sequence and first periodic refresh
    for (int k = 0; k <= 150; k++) begin
      int hit;
      hit = -1;
      for (int v = 0; v < NV; v++) if (VEC_N[v] == n) hit = v;
      chk(cke == 1'b1, "R2", "cke", cke, 1);
      if (hit >= 0) begin
        chk(cmd_now() == VEC_CMD[hit], VEC_REQ[hit], "cmd", cmd_now(), VEC_CMD[hit]);
        chk(ba == VEC_BA[hit], VEC_REQ[hit], "ba", ba, VEC_BA[hit]);
        chk(addr == VEC_ADDR[hit], VEC_REQ[hit], "addr", addr, VEC_ADDR[hit]);
      end else begin
        chk(cmd_now() == 4'b0111, (n < P_PWR) ? "R2" : "R7", "nop", cmd_now(), 4'b0111);
      end
      chk(ready == (n >= READY_N), "R6", "ready", ready, n >= READY_N);
      if (k != 150) step();
    end

    // R8 grant after request, timing window passed
    while (n < 160) step();
    usr_req = 1'b1;
    step();
    chk(usr_gnt == 1'b1, "R8", "gnt after req", usr_gnt, 1);
    chk(cmd_now() == 4'b0111, "R10", "nop under gnt", cmd_now(), 4'b0111);

    // R9 refresh due at 245 is deferred while grant held
    while (n < 260) begin
      step();
      chk(usr_gnt == 1'b1, "R9", "gnt held", usr_gnt, 1);
      chk(cmd_now() == 4'b0111, "R10", "nop under gnt", cmd_now(), 4'b0111);
    end
    usr_req = 1'b0;
    step();
    chk(usr_gnt == 1'b0, "R8", "gnt drop", usr_gnt, 0);
    chk(cmd_now() == 4'b0111, "R9", "no ref yet", cmd_now(), 4'b0111);
    step();
    chk(cmd_now() == 4'b0001, "R9", "deferred ref", cmd_now(), 4'b0001);

    // R9 request colliding with due refresh is held off T_RC
    while (n < 345) step();
    usr_req = 1'b1;
    step();
    chk(cmd_now() == 4'b0001, "R9", "ref before gnt", cmd_now(), 4'b0001);
    chk(usr_gnt == 1'b0, "R9", "no gnt on pend", usr_gnt, 0);
    while (n < 354) begin
      step();
      chk(usr_gnt == 1'b0, "R9", "gnt held off", usr_gnt, 0);
    end
    step();
    chk(usr_gnt == 1'b1, "R9", "gnt after tRC", usr_gnt, 1);
    chk(ready == 1'b1, "R6", "ready sticky", ready, 1);
    usr_req = 1'b0;
    step();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule